// File: doc/BRIEF.md
# Configuration Header Register File with Legacy Interrupt Gating

This block is the target-side configuration register file of a PCI-style function. A host reads and writes it one byte lane at a time through an address, a length of one to four bytes and a 32-bit data word. Each byte has a fixed write mask, so only the bits the header defines as host-writable can change. All other bits read as zero.

The function's logic drives four level-sensitive legacy interrupt requests into the block, and the block latches them. The block drives four external INTx outputs. A disable bit in the Command register gates these outputs. When the bit is set, pending lines drop at the outputs. When it is cleared, they return. The interrupt flag in the Status register always shows the ungated pending state, so software can poll it while the pins are masked.

Top module: `cfg_hdr_intx`

## Requirements
- R1: In the Command register, byte 0x04 accepts writes only on bits 0 to 2, and byte 0x05 accepts writes only on bit 2 (the INTx disable bit, Command bit 10). Every other Command bit reads as 0 whatever value is written.
- R2: Byte 0x0C and byte 0x3C accept any 8-bit value. Every other header byte below 0x40 except the Command bytes and the Status flag reads as 0 and ignores writes.
- R3: Each byte from 0x40 up to CFG_SIZE-1 accepts any 8-bit value.
- R4: A write with length L (1 to 4) at address A stores wdata byte i (bits 8i+7:8i) into byte A+i, for i below L. A byte whose index is CFG_SIZE or more is dropped, and the other bytes of the same write still land.
- R5: A read with length L at address A loads rdata on the next clock edge. rdata byte i holds byte A+i for i below L. Lanes at or above L read 0, and bytes at CFG_SIZE or beyond read 0. A read with L=0 returns 0.
- R6: Status byte 0x06 bit 3 reads 1 exactly when any latched request level is 1, whatever the disable bit holds. Bytes 0x06 and 0x07 ignore writes.
- R7: irq_req is latched on every clock edge. intx_o[i] equals the latched level i ANDed with the inverse of the disable bit, and it is registered one cycle later. While disable is set, level changes never reach intx_o.
- R8: A write that sets the disable bit drops every pending intx_o line one cycle after the Command byte updates. A write that clears it restores them. Rewriting the value the bit already holds changes no output.
- R9: Reset clears every writable byte, the latched levels, rdata and intx_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W (9) | Start byte address |
| len | input | LEN_W (3) | Byte count, 0 to 4 |
| wdata | input | DATA_W (32) | Write data, little-endian lanes |
| rdata | output | DATA_W (32) | Registered read data |
| irq_req | input | NPINS (4) | Interrupt request levels from the function |
| intx_o | output | NPINS (4) | Gated INTx outputs |

## Verification
The hardest situation to reach is an interrupt level that changes while the disable bit is set, followed by re-enabling. The outputs must then show the new levels and not the ones that were pending when the bit was set. Rewriting the bit with the value it already holds must also leave the outputs alone. A directed sequence sets up exactly this order: raise lines, disable, change lines, rewrite disable, re-enable. The random phase mixes request changes with writes of length 1 to 4 that cover byte 0x05, so the bit toggles with different lines pending. After every step the bench compares intx_o and the Status flag against its model.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int CMD_OFS      = 4;
  localparam int STAT_OFS     = 6;
  localparam int CLS_OFS      = 12;
  localparam int ILINE_OFS    = 60;
  localparam int DIS_BIT      = 2;   // bit within byte CMD_OFS+1
  localparam int STAT_IRQ_BIT = 3;

  // Host-writable bits of one configuration byte
  function automatic logic [7:0] byte_wmask(input int idx, input int hdr_bytes);
    if (idx >= hdr_bytes) return 8'hFF;
    case (idx)
      CMD_OFS:            return 8'h07;
      CMD_OFS + 1:        return 8'h01 << DIS_BIT;
      CLS_OFS, ILINE_OFS: return 8'hFF;
      default:            return 8'h00;
    endcase
  endfunction

  // Byte b is covered by an access of n bytes starting at a
  function automatic logic lane_hit(input int b, input int a, input int n, input int lanes);
    return (b >= a) && ((b - a) < n) && ((b - a) < lanes);
  endfunction

  // Merge a write into a byte under its mask
  function automatic logic [7:0] merge_byte(input logic [7:0] old_v, input logic [7:0] new_v,
                                            input logic [7:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
  import cfg_hdr_pkg::*;
#(
  parameter int CFG_SIZE  = 256,
  parameter int HDR_BYTES = 64,
  parameter int ADDR_W    = 9,
  parameter int LEN_W     = 3,
  parameter int DATA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [LEN_W-1:0]      len,
  input  logic [DATA_W-1:0]     wdata,
  output logic [CFG_SIZE*8-1:0] bytes_flat,
  output logic                  cmd_dis
);
  localparam int LANES = DATA_W / 8;
  localparam int SEL_W = $clog2(LANES);

  for (genvar b = 0; b < CFG_SIZE; b++) begin : g_byte
    localparam logic [7:0] MASK = byte_wmask(b, HDR_BYTES);
    if (MASK == 8'h00) begin : g_fixed
      assign bytes_flat[b*8 +: 8] = 8'h00;
    end else begin : g_reg
      logic [7:0]       q;
      logic             hit;
      logic [SEL_W-1:0] sel;
      always_comb begin
        hit = wr_en && lane_hit(b, int'(addr), int'(len), LANES);
        sel = SEL_W'(b - int'(addr));
      end
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= 8'h00;
        else if (hit) q <= merge_byte(q, wdata[{sel, 3'b000} +: 8], MASK);
      end
      assign bytes_flat[b*8 +: 8] = q;
    end
  end

  assign cmd_dis = bytes_flat[(CMD_OFS + 1)*8 + DIS_BIT];

  // Named event: a write reaches the Command high byte
  logic cmd_hi_hit;
  assign cmd_hi_hit = wr_en && lane_hit(CMD_OFS + 1, int'(addr), int'(len), LANES);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_hi_hit |=> $stable(cmd_dis)); // R1
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_hdr_pkg::*;
#(
  parameter int CFG_SIZE = 256,
  parameter int ADDR_W   = 9,
  parameter int LEN_W    = 3,
  parameter int DATA_W   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [LEN_W-1:0]      len,
  input  logic [CFG_SIZE*8-1:0] bytes_flat,
  input  logic                  irq_any,
  output logic [DATA_W-1:0]     rdata
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(len) && (int'(addr) + i) < CFG_SIZE) begin
        if (int'(addr) + i == STAT_OFS)
          rd_word[i*8 +: 8] = 8'(irq_any) << STAT_IRQ_BIT;
        else
          rd_word[i*8 +: 8] = bytes_flat[(int'(addr) + i)*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end
endmodule

// File: rtl/intx_gate.sv
module intx_gate #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_req,
  input  logic             dis,
  output logic             irq_any,
  output logic [NPINS-1:0] intx_o
);
  logic [NPINS-1:0] lvl_q;
  logic             dis_q;
  logic             dis_rise, dis_fall;

  function automatic logic [NPINS-1:0] gate_lines(input logic [NPINS-1:0] lv, input logic d);
    return d ? '0 : lv;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      dis_q  <= 1'b0;
      intx_o <= '0;
    end else begin
      lvl_q  <= irq_req;
      dis_q  <= dis;
      intx_o <= gate_lines(lvl_q, dis);
    end
  end

  assign irq_any  = |lvl_q;
  assign dis_rise = dis & ~dis_q;
  assign dis_fall = ~dis & dis_q;

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> intx_o == '0); // R7
  AST_DROP_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dis_rise |=> intx_o == '0); // R8
  AST_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    dis_fall |=> intx_o == $past(lvl_q)); // R8
  AST_HOLD_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && dis_q) |=> $stable(intx_o)); // R8
endmodule

// File: rtl/cfg_hdr_intx.sv
module cfg_hdr_intx
  import cfg_hdr_pkg::*;
#(
  parameter int CFG_SIZE  = 256,
  parameter int HDR_BYTES = 64,
  parameter int DATA_W    = 32,
  parameter int NPINS     = 4,
  parameter int ADDR_W    = $clog2(CFG_SIZE) + 1,
  parameter int LEN_W     = $clog2(DATA_W / 8) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPINS-1:0]  irq_req,
  output logic [NPINS-1:0]  intx_o
);
  logic [CFG_SIZE*8-1:0] bytes_flat;
  logic                  cmd_dis;
  logic                  irq_any;

  cfg_byte_store #(
    .CFG_SIZE(CFG_SIZE), .HDR_BYTES(HDR_BYTES), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .len(len),
    .wdata(wdata), .bytes_flat(bytes_flat), .cmd_dis(cmd_dis)
  );

  cfg_rd_mux #(
    .CFG_SIZE(CFG_SIZE), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .len(len),
    .bytes_flat(bytes_flat), .irq_any(irq_any), .rdata(rdata)
  );

  intx_gate #(.NPINS(NPINS)) u_gate (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .dis(cmd_dis),
    .irq_any(irq_any), .intx_o(intx_o)
  );

  AST_STATUS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) == STAT_OFS && len != '0 && irq_any && cmd_dis)
      |=> rdata[STAT_IRQ_BIT]); // R6
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && len == '0) |=> rdata == '0); // R5
endmodule

// File: tb/cfg_hdr_intx_bench.sv
module cfg_hdr_intx_bench;
  localparam int SZ = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [2:0]  len = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq_req = '0;
  logic [3:0]  intx_o;

  int n_checks = 0, n_errs = 0;
  bit done = 0;

  logic [7:0] mdl [SZ];
  logic [3:0] mdl_lvl;

  always #2 clk = ~clk;

  cfg_hdr_intx u_cfg_hdr_intx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .len(len), .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .intx_o(intx_o)
  );

  function automatic bit [7:0] tb_mask(int a);
    if (a >= 64) return 8'hFF;
    if (a == 12 || a == 60) return 8'hFF;
    if (a == 4) return 8'h07;
    if (a == 5) return 8'h04;
    return 8'h00;
  endfunction

  function automatic bit tb_dis();
    return mdl[5][2];
  endfunction

  function automatic logic [31:0] tb_read(int a, int n);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++)
      if (i < n && a + i < SZ)
        r[i*8 +: 8] = (a + i == 6) ? {4'b0, |mdl_lvl, 3'b0} : mdl[a + i];
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_intx(string req);
    logic [3:0] e = tb_dis() ? 4'b0 : mdl_lvl;
    check(intx_o == e, req, {28'b0, intx_o}, {28'b0, e});
  endtask

  // Settle: one more edge so registered INTx reflects the latest state
  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_write(int a, int n, logic [31:0] d);
    addr = 9'(a); len = 3'(n); wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < n && i < 4; i++)
      if (a + i < SZ)
        mdl[a + i] = (mdl[a + i] & ~tb_mask(a + i)) | (d[i*8 +: 8] & tb_mask(a + i));
    settle();
  endtask

  task automatic do_read(int a, int n, string req);
    logic [31:0] e = tb_read(a, n);
    addr = 9'(a); len = 3'(n); rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    check(rdata == e, req, rdata, e);
  endtask

  task automatic set_irq(logic [3:0] v);
    irq_req = v; mdl_lvl = v;
    @(posedge clk); @(negedge clk);
    settle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_req = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    foreach (mdl[i]) mdl[i] = 8'h00;
    mdl_lvl = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    do_reset();
    // R9 reset state
    check(rdata == 0, "R9 rdata", rdata, 0);
    check(intx_o == 0, "R9 intx", {28'b0, intx_o}, 0);
    do_read(4, 4, "R9 command/status after reset");

    // R1 command mask
    do_write(4, 2, 32'h0000_FFFF);
    do_read(4, 2, "R1 command writable bits");
    do_write(4, 2, 32'h0000_0000);

    // R2 header bytes
    do_write(12, 1, 32'hA5);
    do_write(60, 1, 32'h3C);
    do_write(8, 4, 32'hFFFF_FFFF);
    do_read(12, 1, "R2 cache line byte");
    do_read(60, 1, "R2 interrupt line byte");
    do_read(8, 4, "R2 fixed header bytes");

    // R3 / R4 / R5 extended region and range edge
    do_write(64, 4, 32'h1122_3344);
    do_read(64, 4, "R3 extended bytes");
    do_read(65, 2, "R5 partial length");
    do_write(SZ - 2, 4, 32'hAABB_CCDD);
    do_read(SZ - 2, 4, "R4 bytes past size dropped");
    do_read(SZ, 4, "R5 out of range reads zero");
    do_read(64, 0, "R5 zero length read");

    // R6 / R7 / R8 interrupt gating sequence
    set_irq(4'b0101);
    check_intx("R7 enabled lines pass");
    do_read(6, 1, "R6 status flag set");
    do_write(5, 1, 32'h04);
    check_intx("R8 disable drops outputs");
    do_read(6, 2, "R6 status raw while disabled");
    set_irq(4'b1010);
    check_intx("R7 change hidden while disabled");
    do_write(4, 2, 32'h0400);
    check_intx("R8 same value rewrite no change");
    do_write(5, 1, 32'h00);
    check_intx("R8 enable restores current lines");
    do_write(6, 2, 32'hFFFF);
    do_read(6, 2, "R6 status ignores writes");
    set_irq(4'b0000);
    do_read(6, 1, "R6 status clears");

    // Random phase
    for (int k = 0; k < 600; k++) begin
      int op = $urandom_range(0, 3);
      int a  = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 72) : $urandom_range(0, SZ + 3);
      int n  = $urandom_range(0, 4);
      if (op == 0) begin
        do_write(a, n, $urandom());
        check_intx("R7 random after write");
      end else if (op == 1) begin
        do_read(a, n, "R4 random read back");
      end else if (op == 2) begin
        set_irq(4'($urandom()));
        check_intx("R7 random irq change");
        do_read(6, 1, "R6 random status");
      end else begin
        do_write(5 - $urandom_range(0, 1), 2, $urandom());
        check_intx("R8 random disable toggle");
      end
    end

    // R9 reset mid-run
    set_irq(4'b1111);
    do_write(64, 4, 32'hDEAD_BEEF);
    do_reset();
    check(intx_o == 0, "R9 intx after reset", {28'b0, intx_o}, 0);
    do_read(64, 4, "R9 storage cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule